// File: doc/BRIEF.md
# Denied transaction abort responder

This block sits between the result of a memory-table permission check and the slave side of an AXI-style memory path. Each incoming request arrives together with its check verdict: allowed, denied, or aborted because the table walk read poisoned data. An allowed request goes out unchanged on the forward request channel, and any write data follows it on the forward write channel. A denied or poisoned request never reaches memory. The block finishes that request itself.

For an aborted write issued by a device, the block accepts every write data beat and throws it away. It then returns one write response with the slave-error code. For an aborted read issued by a device, it returns the full requested burst on its local read-response channel. Each beat carries all-zero data and the slave-error code, and the last-beat flag is set on the final beat. When the aborted access came from the IOMMU itself, no device completion is produced. Instead, a one-cycle fault pulse carries the transaction ID and a cause bit. The bridge merges the local completion channels with the memory-side responses, outside this block.

The block handles one transaction at a time. It takes a new request only when the previous one has fully completed, whether by forwarding or by a local completion.

Top module: `abt_responder`

## Requirements
- R1: A request with verdict 2'b00 (allow) appears exactly once on the forward request channel with unchanged ID, address, burst length and direction, and it produces no local completion or fault.
- R2: For an allowed write, the write data beats pass to the forward write channel in order, with unchanged data and the last flag on beat number len (beats counted from 0).
- R3: A request with any other verdict never appears on the forward request channel, and none of its write beats appear on the forward write channel.
- R4: For an aborted write, all len+1 write beats are accepted and dropped. For a device (non-IOMMU) write, exactly one write response with the request ID and resp 2'b10 follows.
- R5: An aborted device read returns len+1 read beats carrying the request ID, all-zero data and resp 2'b10, with the last flag set on the final beat only.
- R6: An aborted IOMMU-originated access produces no write or read response. It produces exactly one fault pulse, one cycle wide, carrying the request ID and a cause bit of 0 for a denial or 1 for poisoned walk data. For writes the pulse comes after the data beats have been drained.
- R7: Verdict 2'b01 means denied and 2'b10 means poisoned. The reserved value 2'b11 is handled as a denial, with cause 0.
- R8: Request ready is high only when no transaction is in progress, so a new request is not accepted until the previous one has completed.
- R9: A pending read beat, write response or forward request holds its valid and its fields until it is accepted.
- R10: After reset, request ready is high and every valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_req_valid | input | 1 | Incoming request valid |
| s_req_ready | output | 1 | Incoming request accepted |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_id | input | ID_W | Transaction ID |
| s_req_addr | input | ADDR_W | Physical address |
| s_req_len | input | LEN_W | Burst length minus one |
| s_req_iommu | input | 1 | Request issued by the IOMMU |
| s_req_verdict | input | 2 | Check outcome: 00 allow, 01 deny, 10 poisoned, 11 deny |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | DATA_W | Write data |
| s_wlast | input | 1 | Final write beat |
| m_req_valid | output | 1 | Forward request valid |
| m_req_ready | input | 1 | Forward request accepted |
| m_req_write | output | 1 | Forward direction |
| m_req_id | output | ID_W | Forward ID |
| m_req_addr | output | ADDR_W | Forward address |
| m_req_len | output | LEN_W | Forward burst length |
| m_wvalid | output | 1 | Forward write data valid |
| m_wready | input | 1 | Forward write data accepted |
| m_wdata | output | DATA_W | Forward write data |
| m_wlast | output | 1 | Forward final beat |
| s_bvalid | output | 1 | Local write response valid |
| s_bready | input | 1 | Local write response accepted |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_rvalid | output | 1 | Local read beat valid |
| s_rready | input | 1 | Local read beat accepted |
| s_rid | output | ID_W | Read beat ID |
| s_rdata | output | DATA_W | Read beat data |
| s_rresp | output | 2 | Read beat response code |
| s_rlast | output | 1 | Final read beat |
| flt_valid | output | 1 | Fault pulse for IOMMU-originated aborts |
| flt_id | output | ID_W | Faulting transaction ID |
| flt_cause | output | 1 | 0 denied, 1 poisoned walk data |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- Single-beat and 256-beat aborted reads under random backpressure. A beat counter that is off by one would place the last flag on the wrong beat or return the wrong number of beats.
- Aborted writes. A design that responded before draining would leave write beats stuck, or would leak them onto the forward channel.
- IOMMU-originated aborts. A wrong routing choice would show up as a stray read or write response, or as a missing fault pulse.
- The poisoned and reserved verdicts, which catch a swapped cause bit.
- Random mixes of all verdicts, which catch a controller that accepts a new request while a completion is still pending.

// File: rtl/abt_pkg.sv
// Shared types for the abort responder.
// Assumes a 2-bit verdict delivered alongside each request.
package abt_pkg;

    typedef enum logic [1:0] {
        VRD_ALLOW  = 2'd0,
        VRD_DENY   = 2'd1,
        VRD_POISON = 2'd2,
        VRD_RSVD   = 2'd3
    } verdict_e;

    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD_REQ,
        ST_FWD_DATA,
        ST_DRAIN,
        ST_BRESP,
        ST_RBEATS,
        ST_FAULT
    } abt_state_e;

    // Any verdict other than allow ends the transaction locally.
    function automatic logic vrd_aborts(input logic [1:0] v);
        return v != VRD_ALLOW;
    endfunction

    // Only the poisoned code selects cause 1; the reserved code counts as a denial.
    function automatic logic vrd_poison(input logic [1:0] v);
        return v == VRD_POISON;
    endfunction

endpackage

// File: rtl/abt_wpath.sv
// Write data steering. It passes beats to the forward channel, or it
// accepts and drops them. It assumes the controller raises at most one
// enable at a time. Pure combinational; it reports the final-beat handshake.
module abt_wpath #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_en,
    input  logic              drain_en,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic              m_wlast,
    output logic              last_hs
);

    // Route valid/ready according to the active mode.
    always_comb begin
        m_wvalid = fwd_en & s_wvalid;
        m_wdata  = s_wdata;
        m_wlast  = s_wlast;
        s_wready = fwd_en ? m_wready : drain_en;
        last_hs  = s_wvalid & s_wready & s_wlast;
    end

    // R3: while draining an aborted write, nothing reaches the forward channel.
    a_r3_no_leak_when_draining: assert property (@(posedge clk) disable iff (!rst_n)
        drain_en |-> !m_wvalid);

endmodule

// File: rtl/abt_rgen.sv
// Local read-completion generator. On start it emits len+1 beats with a
// fixed fill pattern and the slave-error code, and flags the final beat.
// It assumes start arrives only while it is inactive.
module abt_rgen
    import abt_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int LEN_W     = 8,
    parameter int DATA_W    = 32,
    parameter bit FILL_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   start_id,
    input  logic [LEN_W-1:0]  start_len,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [ID_W-1:0]   s_rid,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rlast,
    output logic              done
);

    logic             active_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [ID_W-1:0]  id_q;

    // Load the burst on start, then advance one beat per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            len_q    <= '0;
            id_q     <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            len_q    <= start_len;
            id_q     <= start_id;
        end else if (active_q && s_rready) begin
            if (cnt_q == len_q) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // The fill pattern is chosen at elaboration.
    generate
        if (FILL_ONES) begin : g_fill_ones
            assign s_rdata = '1;
        end else begin : g_fill_zero
            assign s_rdata = '0;
        end
    endgenerate

    // Drive the beat fields.
    always_comb begin
        s_rvalid = active_q;
        s_rid    = id_q;
        s_rresp  = RESP_SLVERR;
        s_rlast  = active_q && (cnt_q == len_q);
        done     = active_q && s_rready && (cnt_q == len_q);
    end

    // R5: the accepted final beat closes the burst.
    a_r5_last_closes_burst: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && s_rlast && s_rready |=> !s_rvalid);

    // R9: a stalled beat keeps its ID and last flag.
    a_r9_read_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rid) && $stable(s_rlast));

endmodule

// File: rtl/abt_ctrl.sv
// Transaction controller. It accepts one request, latches its fields and
// verdict, and sequences forwarding, drain, write response, read beats
// or the IOMMU fault pulse. It assumes the verdict is valid with
// s_req_valid.
module abt_ctrl
    import abt_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req_valid,
    output logic              s_req_ready,
    input  logic              s_req_write,
    input  logic [ID_W-1:0]   s_req_id,
    input  logic [ADDR_W-1:0] s_req_addr,
    input  logic [LEN_W-1:0]  s_req_len,
    input  logic              s_req_iommu,
    input  logic [1:0]        s_req_verdict,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_write,
    output logic [ID_W-1:0]   m_req_id,
    output logic [ADDR_W-1:0] m_req_addr,
    output logic [LEN_W-1:0]  m_req_len,
    output logic              w_fwd_en,
    output logic              w_drain_en,
    input  logic              w_last_hs,
    output logic              r_start,
    input  logic              r_done,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [ID_W-1:0]   s_bid,
    output logic [1:0]        s_bresp,
    output logic              flt_valid,
    output logic [ID_W-1:0]   flt_id,
    output logic              flt_cause
);

    abt_state_e        st_q, st_d;
    logic              wr_q, iommu_q, poison_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              accept;
    logic              abort_in;

    assign accept   = (st_q == ST_IDLE) && s_req_valid;
    assign abort_in = vrd_aborts(s_req_verdict);

    // Next-state selection for the single transaction in flight.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (s_req_valid) begin
                if (!abort_in)        st_d = ST_FWD_REQ;
                else if (s_req_write) st_d = ST_DRAIN;
                else if (s_req_iommu) st_d = ST_FAULT;
                else                  st_d = ST_RBEATS;
            end
            ST_FWD_REQ:  if (m_req_ready) st_d = wr_q ? ST_FWD_DATA : ST_IDLE;
            ST_FWD_DATA: if (w_last_hs)   st_d = ST_IDLE;
            ST_DRAIN:    if (w_last_hs)   st_d = iommu_q ? ST_FAULT : ST_BRESP;
            ST_BRESP:    if (s_bready)    st_d = ST_IDLE;
            ST_RBEATS:   if (r_done)      st_d = ST_IDLE;
            ST_FAULT:                     st_d = ST_IDLE;
            default:                      st_d = ST_IDLE;
        endcase
    end

    // State register and request field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            wr_q     <= 1'b0;
            iommu_q  <= 1'b0;
            poison_q <= 1'b0;
            id_q     <= '0;
            addr_q   <= '0;
            len_q    <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                wr_q     <= s_req_write;
                iommu_q  <= s_req_iommu;
                poison_q <= vrd_poison(s_req_verdict);
                id_q     <= s_req_id;
                addr_q   <= s_req_addr;
                len_q    <= s_req_len;
            end
        end
    end

    // Decode outputs from the state and latched fields.
    always_comb begin
        s_req_ready = (st_q == ST_IDLE);
        m_req_valid = (st_q == ST_FWD_REQ);
        m_req_write = wr_q;
        m_req_id    = id_q;
        m_req_addr  = addr_q;
        m_req_len   = len_q;
        w_fwd_en    = (st_q == ST_FWD_DATA);
        w_drain_en  = (st_q == ST_DRAIN);
        r_start     = accept && abort_in && !s_req_write && !s_req_iommu;
        s_bvalid    = (st_q == ST_BRESP);
        s_bid       = id_q;
        s_bresp     = RESP_SLVERR;
        flt_valid   = (st_q == ST_FAULT);
        flt_id      = id_q;
        flt_cause   = poison_q;
    end

    // R1: a forward request stays put until taken.
    a_r1_fwd_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_req_id)
                                        && $stable(m_req_addr) && $stable(m_req_len));

    // R9: the write response waits for its acceptance.
    a_r9_bresp_held: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bid));

    // R6: the fault indication is a single-cycle pulse.
    a_r6_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid);

    // R8: after accepting a request the block is busy in the next cycle.
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid && s_req_ready |=> !s_req_ready);

endmodule

// File: rtl/abt_responder.sv
// Top of the abort responder. It ties the controller, the write data
// steering and the local read generator together. It assumes the verdict
// comes from the permission checker with each request, and that the local
// completion channels are merged with memory responses outside the block.
module abt_responder
    import abt_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int DATA_W    = 32,
    parameter bit FILL_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req_valid,
    output logic              s_req_ready,
    input  logic              s_req_write,
    input  logic [ID_W-1:0]   s_req_id,
    input  logic [ADDR_W-1:0] s_req_addr,
    input  logic [LEN_W-1:0]  s_req_len,
    input  logic              s_req_iommu,
    input  logic [1:0]        s_req_verdict,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_wlast,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_write,
    output logic [ID_W-1:0]   m_req_id,
    output logic [ADDR_W-1:0] m_req_addr,
    output logic [LEN_W-1:0]  m_req_len,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic              m_wlast,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [ID_W-1:0]   s_bid,
    output logic [1:0]        s_bresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [ID_W-1:0]   s_rid,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rlast,
    output logic              flt_valid,
    output logic [ID_W-1:0]   flt_id,
    output logic              flt_cause
);

    logic w_fwd_en, w_drain_en, w_last_hs;
    logic r_start, r_done;

    abt_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
        .s_req_write(s_req_write), .s_req_id(s_req_id),
        .s_req_addr(s_req_addr), .s_req_len(s_req_len),
        .s_req_iommu(s_req_iommu), .s_req_verdict(s_req_verdict),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
        .m_req_write(m_req_write), .m_req_id(m_req_id),
        .m_req_addr(m_req_addr), .m_req_len(m_req_len),
        .w_fwd_en(w_fwd_en), .w_drain_en(w_drain_en), .w_last_hs(w_last_hs),
        .r_start(r_start), .r_done(r_done),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
        .flt_valid(flt_valid), .flt_id(flt_id), .flt_cause(flt_cause)
    );

    abt_wpath #(.DATA_W(DATA_W)) u_wpath (
        .clk(clk), .rst_n(rst_n),
        .fwd_en(w_fwd_en), .drain_en(w_drain_en),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wlast(m_wlast),
        .last_hs(w_last_hs)
    );

    abt_rgen #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .FILL_ONES(FILL_ONES)) u_rgen (
        .clk(clk), .rst_n(rst_n),
        .start(r_start), .start_id(s_req_id), .start_len(s_req_len),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
        .done(r_done)
    );

    // R8: local read beats only while a transaction is in progress.
    a_r8_rbeats_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_req_ready);

    // R8: at most one outbound channel is active at any time.
    a_r8_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_rvalid, s_bvalid, flt_valid, m_req_valid, m_wvalid}));

endmodule

// File: tb/abt_responder_tb.sv
`timescale 1ns/1ps
module abt_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 4, ADDR_W = 32, LEN_W = 8, DATA_W = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic s_req_valid = 0, s_req_write = 0, s_req_iommu = 0;
    logic [ID_W-1:0] s_req_id = '0;
    logic [ADDR_W-1:0] s_req_addr = '0;
    logic [LEN_W-1:0] s_req_len = '0;
    logic [1:0] s_req_verdict = '0;
    logic s_wvalid = 0, s_wlast = 0;
    logic [DATA_W-1:0] s_wdata = '0;
    logic m_req_ready = 1, m_wready = 1, s_bready = 1, s_rready = 1;
    logic s_req_ready, s_wready, m_req_valid, m_req_write, m_wvalid, m_wlast;
    logic [ID_W-1:0] m_req_id, s_bid, s_rid, flt_id;
    logic [ADDR_W-1:0] m_req_addr;
    logic [LEN_W-1:0] m_req_len;
    logic [DATA_W-1:0] m_wdata, s_rdata;
    logic [1:0] s_bresp, s_rresp;
    logic s_bvalid, s_rvalid, s_rlast, flt_valid, flt_cause;

    abt_responder #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_write(s_req_write),
        .s_req_id(s_req_id), .s_req_addr(s_req_addr), .s_req_len(s_req_len),
        .s_req_iommu(s_req_iommu), .s_req_verdict(s_req_verdict),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_write(m_req_write),
        .m_req_id(m_req_id), .m_req_addr(m_req_addr), .m_req_len(m_req_len),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wlast(m_wlast),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
        .s_rresp(s_rresp), .s_rlast(s_rlast),
        .flt_valid(flt_valid), .flt_id(flt_id), .flt_cause(flt_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int n_mreq = 0, n_mw = 0, n_sw = 0, n_b = 0, n_r = 0, n_rlast = 0, n_flt = 0;
    int base_mw = 0, base_r = 0, exp_len = 0, exp_id = 0;
    logic [DATA_W-1:0] wdat [0:255];
    logic [ID_W-1:0] got_mid, got_bid, got_fid, prev_rid, prev_bid;
    logic [ADDR_W-1:0] got_maddr;
    logic [LEN_W-1:0] got_mlen;
    logic got_mwr, got_cause;
    logic [1:0] got_bresp;
    logic prev_rstall = 0, prev_bstall = 0, prev_flt = 0;
    bit bp_en = 0;

    // Counted check with one FAIL line per mismatch.
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
            summary();
            $finish;
        end
    end

    // Random backpressure on the ready inputs, driven after the edge.
    always @(posedge clk) begin
        #1;
        m_req_ready <= bp_en ? (($urandom % 4) != 0) : 1'b1;
        m_wready    <= bp_en ? (($urandom % 4) != 0) : 1'b1;
        s_bready    <= bp_en ? (($urandom % 3) != 0) : 1'b1;
        s_rready    <= bp_en ? (($urandom % 3) != 0) : 1'b1;
    end

    // Monitor, sampling at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_req_valid && m_req_ready) begin
                n_mreq++; got_mid = m_req_id; got_maddr = m_req_addr;
                got_mlen = m_req_len; got_mwr = m_req_write;
            end
            if (m_wvalid && m_wready) begin
                chk(m_wdata == wdat[n_mw - base_mw], "R2", "fwd wdata", m_wdata, wdat[n_mw - base_mw]);
                chk(m_wlast == ((n_mw - base_mw) == exp_len), "R2", "fwd wlast", m_wlast, (n_mw - base_mw) == exp_len);
                n_mw++;
            end
            if (s_wvalid && s_wready) n_sw++;
            if (prev_bstall) chk(s_bvalid && s_bid == prev_bid, "R9", "bresp held", s_bvalid, 1);
            if (s_bvalid && s_bready) begin
                n_b++; got_bid = s_bid; got_bresp = s_bresp;
            end
            if (prev_rstall) chk(s_rvalid && s_rid == prev_rid, "R9", "read beat held", s_rvalid, 1);
            if (s_rvalid && s_rready) begin
                chk(s_rdata == '0, "R5", "rdata", s_rdata, 0);
                chk(s_rresp == 2'b10, "R5", "rresp", s_rresp, 2);
                chk(s_rid == exp_id[ID_W-1:0], "R5", "rid", s_rid, exp_id);
                chk(s_rlast == ((n_r - base_r) == exp_len), "R5", "rlast", s_rlast, (n_r - base_r) == exp_len);
                n_r++;
                if (s_rlast) n_rlast++;
            end
            if (flt_valid) begin
                chk(!prev_flt, "R6", "fault pulse width", 2, 1);
                n_flt++; got_fid = flt_id; got_cause = flt_cause;
            end
            prev_rstall = s_rvalid && !s_rready; prev_rid = s_rid;
            prev_bstall = s_bvalid && !s_bready; prev_bid = s_bid;
            prev_flt = flt_valid;
        end
    end

    // One full transaction with its expected outcome computed from the requirements.
    task automatic run_txn(input bit wr, input int id, input int addr, input int len,
                           input bit iom, input logic [1:0] vrd);
        bit ab, dev, poison;
        int b_mreq, b_mw, b_sw, b_b, b_r, b_rl, b_flt;
        ab = (vrd != 2'b00); dev = !iom; poison = (vrd == 2'b10);
        @(posedge clk); #1;
        for (int i = 0; i < 256; i++) wdat[i] = $urandom;
        exp_id = id; exp_len = len;
        b_mreq = n_mreq; b_mw = n_mw; b_sw = n_sw; b_b = n_b; b_r = n_r; b_rl = n_rlast; b_flt = n_flt;
        base_mw = n_mw; base_r = n_r;
        s_req_valid = 1; s_req_write = wr; s_req_id = id[ID_W-1:0]; s_req_addr = addr;
        s_req_len = len[LEN_W-1:0]; s_req_iommu = iom; s_req_verdict = vrd;
        @(negedge clk);
        while (!s_req_ready) @(negedge clk);
        @(posedge clk); #1;
        s_req_valid = 0;
        @(negedge clk);
        chk(!s_req_ready, "R8", "ready while busy", s_req_ready, 0);
        if (wr) begin
            for (int b = 0; b <= len; b++) begin
                @(posedge clk); #1;
                s_wvalid = 1; s_wdata = wdat[b]; s_wlast = (b == len);
                @(negedge clk);
                while (!s_wready) @(negedge clk);
            end
            @(posedge clk); #1;
            s_wvalid = 0; s_wlast = 0;
        end
        @(negedge clk);
        while (!s_req_ready) @(negedge clk);
        chk((n_mreq - b_mreq) == (ab ? 0 : 1), ab ? "R3" : "R1", "forward requests", n_mreq - b_mreq, ab ? 0 : 1);
        if (!ab) begin
            chk(got_mid == id[ID_W-1:0], "R1", "fwd id", got_mid, id);
            chk(got_maddr == addr, "R1", "fwd addr", got_maddr, addr);
            chk(got_mlen == len[LEN_W-1:0] && got_mwr == wr, "R1", "fwd len/dir", got_mlen, len);
        end
        chk((n_mw - b_mw) == ((!ab && wr) ? len + 1 : 0), ab ? "R3" : "R2", "fwd beats", n_mw - b_mw, (!ab && wr) ? len + 1 : 0);
        chk((n_sw - b_sw) == (wr ? len + 1 : 0), "R4", "write beats taken", n_sw - b_sw, wr ? len + 1 : 0);
        chk((n_b - b_b) == ((ab && wr && dev) ? 1 : 0), "R4", "write responses", n_b - b_b, (ab && wr && dev) ? 1 : 0);
        if (ab && wr && dev) chk(got_bid == id[ID_W-1:0] && got_bresp == 2'b10, "R4", "bid/bresp", got_bresp, 2);
        chk((n_r - b_r) == ((ab && !wr && dev) ? len + 1 : 0), "R5", "read beats", n_r - b_r, (ab && !wr && dev) ? len + 1 : 0);
        chk((n_rlast - b_rl) == ((ab && !wr && dev) ? 1 : 0), "R5", "rlast count", n_rlast - b_rl, (ab && !wr && dev) ? 1 : 0);
        chk((n_flt - b_flt) == ((ab && iom) ? 1 : 0), "R6", "fault pulses", n_flt - b_flt, (ab && iom) ? 1 : 0);
        if (ab && iom) begin
            chk(got_fid == id[ID_W-1:0], "R6", "fault id", got_fid, id);
            chk(got_cause == poison, vrd == 2'b11 ? "R7" : "R6", "fault cause", got_cause, poison);
        end
    endtask

    initial begin
        void'($urandom(32'd20511));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(s_req_ready == 1, "R10", "ready after reset", s_req_ready, 1);
        chk(!m_req_valid && !m_wvalid && !s_bvalid && !s_rvalid && !flt_valid, "R10", "valids after reset", 1, 0);
        run_txn(0, 3, 32'h1000, 3, 0, 2'b00);    // R1 allowed read
        run_txn(1, 5, 32'h2040, 2, 0, 2'b00);    // R2 allowed write
        run_txn(1, 7, 32'h3000, 0, 0, 2'b01);    // R4 single-beat denied write
        run_txn(1, 8, 32'h3100, 4, 0, 2'b01);    // R4 burst denied write
        run_txn(0, 9, 32'h4000, 0, 0, 2'b01);    // R5 single-beat denied read
        run_txn(0, 10, 32'h5000, 5, 0, 2'b10);   // R5 poisoned read
        run_txn(1, 11, 32'h5100, 1, 0, 2'b10);   // R4 poisoned write
        run_txn(1, 12, 32'h6000, 1, 1, 2'b01);   // R6 IOMMU denied write
        run_txn(0, 13, 32'h6100, 3, 1, 2'b10);   // R6 IOMMU poisoned read
        run_txn(0, 14, 32'h7000, 2, 0, 2'b11);   // R7 reserved verdict, device
        run_txn(1, 15, 32'h7100, 0, 1, 2'b11);   // R7 reserved verdict, IOMMU
        run_txn(0, 1, 32'h8000, 2, 1, 2'b00);    // R1 allowed IOMMU read
        bp_en = 1;
        run_txn(0, 2, 32'h9000, 255, 0, 2'b01);  // R5 R9 full-length denied read
        run_txn(1, 4, 32'h9100, 6, 0, 2'b00);    // R2 R9 allowed write under backpressure
        for (int t = 0; t < 60; t++) begin
            logic [1:0] v;
            v = 2'($urandom % 4);
            run_txn(1'($urandom % 2), int'($urandom % 16), int'($urandom), int'($urandom % 8),
                    (($urandom % 4) == 0), v);
        end
        summary();
        $finish;
    end
endmodule